// File: doc/BRIEF.md
# Dual-Format Stereo Audio Serializer

This block turns parallel stereo samples into a serial audio stream and acts as the clock master for that stream. A left and a right sample, each `SAMPLE_W` bits wide, are offered on a valid/ready handshake in the system clock domain. The block divides the system clock by an even ratio `DIV` to make a bit clock. It drives a word-select line that marks the channel being sent and a serial data line that carries both channels in turn.

Each frame has two channel slots of `SLOT_W` bit-clock periods each. The left slot comes first. Samples go out most significant bit first, and any slot positions after the sample bits are sent as zeros. A static format input picks one of two framings. With the input at 0 the stream is I2S: word-select is low for left, and data starts one bit clock after the word-select edge. With the input at 1 the stream is left-justified: word-select is high for left, and data starts on the word-select edge. A new pair and a new format setting are taken only at a frame boundary. If no pair is offered there, the block sends the previous pair again.

Top module: `audio_ser_top`

## Requirements
- R1: With `fmt_lj` = 1 (left-justified), `wsel` is 1 for all 32 bit periods of the left slot and 0 for all 32 of the right slot. `wsel` changes only at the start of a slot.
- R2: With `fmt_lj` = 0 (I2S), `wsel` is 0 for the left slot and 1 for the right slot.
- R3: In left-justified framing, the MSB of each sample is sent in bit period 0 of its slot and the remaining bits follow in descending order. Bit periods 24 to 31 carry 0.
- R4: In I2S framing, bit period 0 of each slot carries 0, the sample is sent MSB first in bit periods 1 to 24, and bit periods 25 to 31 carry 0.
- R5: `wsel` and `sdata` change only in the system clock cycle where `bclk` falls, so they are stable at every rising edge of `bclk`.
- R6: `bclk` is high for `DIV/2` system clock cycles and low for `DIV/2` cycles. A frame lasts 64 bit periods.
- R7: `in_ready` is high for one system clock cycle at each frame boundary, once every 64*`DIV` cycles. A pair accepted there (`in_valid` and `in_ready` both 1) is the pair sent in the frame that starts at that boundary.
- R8: If `in_valid` is 0 at a frame boundary, the frame that follows resends the previous pair. That pair is all zeros if none has been accepted since reset.
- R9: A change of `fmt_lj` in the middle of a frame does not affect that frame. It takes effect from the next frame boundary.
- R10: While `rst_n` is 0, `bclk`, `wsel`, `sdata` and `in_ready` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_lj | input | 1 | Framing select: 0 = I2S, 1 = left-justified |
| in_valid | input | 1 | A stereo pair is offered |
| in_left | input | SAMPLE_W | Left sample |
| in_right | input | SAMPLE_W | Right sample |
| in_ready | output | 1 | Frame boundary: the offered pair is taken now |
| bclk | output | 1 | Bit clock, system clock / DIV |
| wsel | output | 1 | Word-select (channel marker) |
| sdata | output | 1 | Serial data, MSB first |

## Verification
The sample patterns are chosen to catch specific bit faults. Asymmetric words such as 0xA5C3F1 and 0x5A3C0E catch bit-order and channel-swap faults. The patterns 0x800001 and 0x7FFFFE isolate the MSB and LSB ends, which exposes an off-by-one in the I2S delay or a lost final bit. All-ones against all-zeros shows leakage into the zero padding slots. Idle stretches with no valid pair check that the last pair is resent. Format flips placed in the middle of a frame show whether the framing is switched early. Each frame is rebuilt from the bench's own slot image and compared bit by bit for both word-select and data.

// File: rtl/aser_pkg.sv
package aser_pkg;

  typedef enum logic {
    FMT_I2S = 1'b0,
    FMT_LJ  = 1'b1
  } aser_fmt_e;

  // word-select level for a channel under a framing
  function automatic logic ws_level(input aser_fmt_e f, input logic right_ch);
    return (f == FMT_LJ) ? !right_ch : right_ch;
  endfunction

  // bit periods between the slot start and the sample MSB
  function automatic int lead_gap(input aser_fmt_e f);
    return (f == FMT_LJ) ? 0 : 1;
  endfunction

endpackage

// File: rtl/aser_bclk_gen.sv
module aser_bclk_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic bclk_o,
  output logic fall_next_o
);
  localparam int HALF  = DIV / 2;
  localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV - 1);
  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             bclk_q;

  initial begin
    cfg_div_even: assert (DIV >= 2 && (DIV % 2) == 0)
      else $error("DIV must be even and at least 2");
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else begin
      cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
      if (cnt_q == CNT_MID)       bclk_q <= 1'b1;
      else if (cnt_q == CNT_LAST) bclk_q <= 1'b0;
    end
  end

  // high in the cycle whose closing edge drops the bit clock
  assign fall_next_o = (cnt_q == CNT_LAST);
  assign bclk_o      = bclk_q;

endmodule

// File: rtl/aser_framer.sv
module aser_framer
  import aser_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fall_next,
  input  logic                bclk_i,
  input  logic                fmt_i,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  output logic                in_ready,
  output logic                ws_o,
  output logic                sdata_o
);
  localparam int SLOT_LG  = $clog2(SLOT_W);
  localparam int FRAME_LG = SLOT_LG + 1;
  localparam logic [FRAME_LG-1:0] POS_LAST = '1;

  initial begin
    cfg_geometry: assert (SAMPLE_W < SLOT_W && (1 << SLOT_LG) == SLOT_W)
      else $error("SLOT_W must be a power of two above SAMPLE_W");
  end

  logic [FRAME_LG-1:0] pos_q, pos_nxt;
  logic [SAMPLE_W-1:0] left_q, right_q, left_nxt, right_nxt;
  aser_fmt_e           fmt_q, fmt_nxt;
  logic                ws_q, sdata_q;

  // named events for the checks below
  logic frame_wrap, pair_take, slot_start;

  function automatic logic pick_bit(input aser_fmt_e f,
                                    input logic [FRAME_LG-1:0] p,
                                    input logic [SAMPLE_W-1:0] l,
                                    input logic [SAMPLE_W-1:0] r);
    logic [SAMPLE_W-1:0] w;
    int idx;
    w   = p[FRAME_LG-1] ? r : l;
    idx = int'(p[SLOT_LG-1:0]) - lead_gap(f);
    if (idx < 0 || idx >= SAMPLE_W) return 1'b0;
    w = w << idx;
    return w[SAMPLE_W-1];
  endfunction

  assign frame_wrap = (pos_q == POS_LAST);
  assign in_ready   = fall_next && frame_wrap;
  assign pair_take  = in_ready && in_valid;
  assign slot_start = (pos_q[SLOT_LG-1:0] == '0);

  always_comb begin
    pos_nxt   = frame_wrap ? '0 : pos_q + 1'b1;
    left_nxt  = pair_take ? in_left  : left_q;
    right_nxt = pair_take ? in_right : right_q;
    fmt_nxt   = frame_wrap ? aser_fmt_e'(fmt_i) : fmt_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q   <= POS_LAST;
      left_q  <= '0;
      right_q <= '0;
      fmt_q   <= FMT_I2S;
      ws_q    <= 1'b0;
      sdata_q <= 1'b0;
    end else if (fall_next) begin
      pos_q   <= pos_nxt;
      left_q  <= left_nxt;
      right_q <= right_nxt;
      fmt_q   <= fmt_nxt;
      ws_q    <= ws_level(fmt_nxt, pos_nxt[FRAME_LG-1]);
      sdata_q <= pick_bit(fmt_nxt, pos_nxt, left_nxt, right_nxt);
    end
  end

  assign ws_o    = ws_q;
  assign sdata_o = sdata_q;

  assert_ws_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ws_o) |-> $fell(bclk_i));

  assert_data_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata_o) |-> $fell(bclk_i));

  assert_ws_slot_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ws_o) |-> slot_start);

  assert_i2s_lead_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_q == FMT_I2S && slot_start) |-> !sdata_o);

  assert_ready_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready);

endmodule

// File: rtl/audio_ser_top.sv
module audio_ser_top #(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  parameter int DIV      = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fmt_lj,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  output logic                in_ready,
  output logic                bclk,
  output logic                wsel,
  output logic                sdata
);
  logic fall_next;

  aser_bclk_gen #(.DIV(DIV)) u_bclk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bclk_o      (bclk),
    .fall_next_o (fall_next)
  );

  aser_framer #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .fall_next (fall_next),
    .bclk_i    (bclk),
    .fmt_i     (fmt_lj),
    .in_valid  (in_valid),
    .in_left   (in_left),
    .in_right  (in_right),
    .in_ready  (in_ready),
    .ws_o      (wsel),
    .sdata_o   (sdata)
  );

endmodule

// File: tb/sim_audio_ser_top.sv
module sim_audio_ser_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int HALF       = DIV / 2;
  localparam int FRAME_CYC  = 64 * DIV;

  typedef struct { logic [23:0] l; logic [23:0] r; } pair_t;
  typedef struct { pair_t p; logic lj; string tag; } frame_t;

  logic clk = 1'b0, rst_n = 1'b0, fmt_lj = 1'b1, in_valid = 1'b0;
  logic [23:0] in_left = '0, in_right = '0;
  logic in_ready, bclk, wsel, sdata;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  string scen = "R8";
  pair_t  expq[$];
  frame_t frq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_ser_top #(.SAMPLE_W(24), .SLOT_W(32), .DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .fmt_lj(fmt_lj), .in_valid(in_valid),
    .in_left(in_left), .in_right(in_right), .in_ready(in_ready),
    .bclk(bclk), .wsel(wsel), .sdata(sdata));

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] slot_image(input logic lj, input logic [23:0] w);
    return lj ? {w, 8'h00} : {1'b0, w, 7'h00};
  endfunction

  task automatic send_pair(input logic [23:0] l, input logic [23:0] r);
    pair_t e;
    @(posedge clk); #1;
    in_valid = 1'b1; in_left = l; in_right = r;
    e.l = l; e.r = r;
    expq.push_back(e);
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // monitor / scoreboard
  logic pb = 1'b0, pw = 1'b0, ps = 1'b0;
  int run = 0, gap = 0, rises = 0;
  bit seen_edge = 1'b0, seen_ready = 1'b0, have_cur = 1'b0;
  pair_t  last_pair = '{l: '0, r: '0};
  frame_t cur;
  logic [63:0] act_ws, act_dat, exp_ws, exp_dat;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      // R5: outputs move only with a falling bit clock
      if (wsel !== pw || sdata !== ps)
        check(pb == 1'b1 && bclk == 1'b0, "R5", "output change off bclk fall",
              {62'd0, pb, bclk}, 64'd2);
      // R6: half-period length
      if (bclk !== pb) begin
        if (seen_edge) check(run == HALF, "R6", "bclk half period", run, HALF);
        seen_edge = 1'b1; run = 1;
      end else run++;
      // R7: frame boundary handshake
      gap++;
      if (in_ready) begin
        frame_t f;
        if (seen_ready) check(gap == FRAME_CYC, "R6 R7", "frame length", gap, FRAME_CYC);
        seen_ready = 1'b1; gap = 0;
        if (in_valid) begin
          if (expq.size() == 0) check(1'b0, "R7", "unexpected take", 1, 0);
          else last_pair = expq.pop_front();
        end
        f.p = last_pair; f.lj = fmt_lj; f.tag = scen;
        frq.push_back(f);
      end
      // bit-clock rise: capture a slot
      if (bclk && !pb) begin
        if (rises > 0) begin
          int s;
          s = (rises - 1) % 64;
          if (s == 0) begin
            if (frq.size() == 0) begin
              check(1'b0, "R7", "no frame boundary seen", 0, 1);
              have_cur = 1'b0;
            end else begin
              cur = frq.pop_front();
              have_cur = 1'b1;
              exp_dat = {slot_image(cur.lj, cur.p.l), slot_image(cur.lj, cur.p.r)};
              exp_ws  = cur.lj ? {32'hFFFF_FFFF, 32'h0} : {32'h0, 32'hFFFF_FFFF};
            end
          end
          if (have_cur) begin
            act_ws[63-s]  = wsel;
            act_dat[63-s] = sdata;
            if (s == 63) begin
              check(act_ws == exp_ws, cur.lj ? {"R1 ", cur.tag} : {"R2 ", cur.tag},
                    "word-select pattern", act_ws, exp_ws);
              check(act_dat == exp_dat, cur.lj ? {"R3 ", cur.tag} : {"R4 ", cur.tag},
                    "frame data", act_dat, exp_dat);
            end
          end
        end
        rises++;
      end
      pb = bclk; pw = wsel; ps = sdata;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(bclk == 1'b0, "R10", "bclk in reset", bclk, 0);
    check(wsel == 1'b0, "R10", "wsel in reset", wsel, 0);
    check(sdata == 1'b0, "R10", "sdata in reset", sdata, 0);
    check(in_ready == 1'b0, "R10", "in_ready in reset", in_ready, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    // left-justified, back to back
    scen = "R3";
    send_pair(24'hA5C3F1, 24'h5A3C0E);
    send_pair(24'h800001, 24'h7FFFFE);
    send_pair(24'hFFFFFF, 24'h000000);
    // idle: previous pair resent (R8)
    scen = "R8";
    repeat (2 * FRAME_CYC) @(posedge clk);
    // mid-frame switch to I2S (R9)
    do @(negedge clk); while (!in_ready);
    repeat (FRAME_CYC / 3) @(posedge clk);
    #1; fmt_lj = 1'b0; scen = "R9";
    repeat (FRAME_CYC) @(posedge clk);
    scen = "R4";
    send_pair(24'h800001, 24'h7FFFFE);
    send_pair(24'hA5C3F1, 24'h5A3C0E);
    send_pair(24'h000000, 24'hFFFFFF);
    // mid-frame switch back (R9)
    do @(negedge clk); while (!in_ready);
    repeat (FRAME_CYC / 2) @(posedge clk);
    #1; fmt_lj = 1'b1; scen = "R9";
    send_pair(24'h123456, 24'hFEDCBA);
    repeat (3 * FRAME_CYC) @(posedge clk);
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule